// File: doc/BRIEF.md
# Configuration Index/Data Port

This block gives a host a two-byte window into a chip's configuration space. The host writes a register number into the index byte (address bit 0). It then reads or writes the selected register through the data byte (address bit 1). One global register chooses which logical device the upper part of the space refers to. Every register from 0x30 upward is private to the logical device chosen there.

Two logical devices are built in, numbered 0x09 and 0x14. Each one holds an activation bit, a memory-versus-I/O mapping bit and a 16-bit I/O base address. The global space adds a fixed identification byte and seven writable pin-option bytes. It also has an exit register: writing the closing code to it ends the configuration session.

For each logical device the block drives a registered enable flag and its decoded base address, so that downstream address decoders can claim I/O cycles.

Top module: `cfgport_top`

## Requirements
- R1: After a synchronous reset, the following all hold:
  - The index reads 0x00, `bus_rdata` is 0x00 and `sess_end` is 0.
  - Both logical devices are inactive with base 0x0000.
  - All pin-option bytes read 0x00.
- R2: A write with `bus_addr`=0 loads the index. A read with `bus_addr`=0 returns the index. A data access (`bus_addr`=1) targets the register the index names.
- R3: Index 0x20 always reads 0xF2, and writes to it have no effect.
- R4: Index 0x07 holds a readable, writable logical device number. Registers at index 0x30 and above reach only the device whose number (0x09 is device 0, 0x14 is device 1) equals that value.
- R5: Bit 0 of index 0x30 is the activation bit of the selected device. It reads back in bit 0 with the other bits zero.
- R6: Index 0x60 holds the high byte and index 0x61 the low byte of the device base. `dev_base` (device 0 in bits 15:0, device 1 in bits 31:16) shows {high, low} one clock after the register changes.
- R7: A device's `dev_en` bit is 1 exactly when three things hold: its activation bit is 1, bit 0 of its index 0x50 is 0 (I/O mapped, not memory mapped) and its base is nonzero. The bit follows one clock after the registers change.
- R8: When the selected device number matches no implemented device, banked reads return 0x00 and banked writes change nothing.
- R9: Indices 0x22 to 0x25 and 0x2B to 0x2D are seven independent writable bytes that read back what was written.
- R10: Any index that R2 to R9 and R11 do not define reads 0x00, and writes to it are ignored.
- R11: Writing 0x02 to index 0x02 raises `sess_end` for exactly one clock and returns the index to 0x00. Writing any other value there has no effect.
- R12: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 1 | 0 selects index byte, 1 selects data byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_en | output | 2 | Per-device decode enable |
| dev_base | output | 32 | Per-device I/O base, 16 bits each |
| sess_end | output | 1 | One-clock pulse when the session is closed |

## Verification
The embedded assertions check several rules on every cycle:
- The exit pulse lasts a single clock and coincides with an index of zero.
- An enabled device never shows a zero base, and the base output tracks the base registers with one cycle of lag.
- Writes aimed at another device leave a device's state untouched.
- Read data holds between reads, and the identification byte is always returned for index 0x20.

Only the bench's scenarios can show the rest:
- Banking is routed to the right device and unknown device numbers behave as empty.
- Pin bytes round-trip.
- Undefined indices read as zero.
- The mapping bit gates the enable.
- A non-closing value written to the exit register does nothing.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DW = 8;
  localparam int BASE_W = 2 * DW;

  localparam logic [DW-1:0] IDX_EXIT    = 8'h02;
  localparam logic [DW-1:0] IDX_LDSEL   = 8'h07;
  localparam logic [DW-1:0] IDX_DEVID   = 8'h20;
  localparam logic [DW-1:0] IDX_BANKED  = 8'h30;
  localparam logic [DW-1:0] IDX_ACT     = 8'h30;
  localparam logic [DW-1:0] IDX_MAP     = 8'h50;
  localparam logic [DW-1:0] IDX_BASE_HI = 8'h60;
  localparam logic [DW-1:0] IDX_BASE_LO = 8'h61;
  localparam logic [DW-1:0] EXIT_CODE   = 8'h02;

  localparam int NPIN   = 7;
  localparam int SLOT_W = $clog2(NPIN);

  // Pin-option bytes occupy two runs: 0x22..0x25 and 0x2B..0x2D
  function automatic logic pin_hit(input logic [DW-1:0] idx);
    return ((idx >= 8'h22) && (idx <= 8'h25)) || ((idx >= 8'h2B) && (idx <= 8'h2D));
  endfunction

  function automatic logic [SLOT_W-1:0] pin_slot(input logic [DW-1:0] idx);
    logic [DW-1:0] s;
    if (idx <= 8'h25) s = idx - 8'h22;
    else              s = idx - 8'h2B + 8'd4;
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/cfgport_glob.sv
module cfgport_glob
  import cfgport_pkg::*;
#(
  parameter logic [DW-1:0] DEV_ID  = 8'hF2,
  parameter logic [DW-1:0] PIN_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_o,
  output logic [DW-1:0] ldsel_o,
  output logic [DW-1:0] rd_byte_o,
  output logic          end_o
);
  logic [DW-1:0] idx_q, ldsel_q;
  logic [DW-1:0] pin_q [NPIN];
  logic          end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      ldsel_q <= '0;
      end_q   <= 1'b0;
      for (int i = 0; i < NPIN; i++) pin_q[i] <= PIN_RST;
    end else begin
      end_q <= 1'b0;
      if (idx_wr) begin
        idx_q <= wdata;
      end else if (data_wr) begin
        if (idx_q == IDX_EXIT) begin
          if (wdata == EXIT_CODE) begin
            end_q <= 1'b1;
            idx_q <= '0;
          end
        end else if (idx_q == IDX_LDSEL) begin
          ldsel_q <= wdata;
        end else if (pin_hit(idx_q)) begin
          pin_q[pin_slot(idx_q)] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rd_byte_o = '0;
    if (idx_q == IDX_LDSEL)      rd_byte_o = ldsel_q;
    else if (idx_q == IDX_DEVID) rd_byte_o = DEV_ID;
    else if (pin_hit(idx_q))     rd_byte_o = pin_q[pin_slot(idx_q)];
  end

  assign idx_o   = idx_q;
  assign ldsel_o = ldsel_q;
  assign end_o   = end_q;

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    end_q |=> !end_q);
  a_r11_index_home: assert property (@(posedge clk) disable iff (rst)
    end_q |-> (idx_q == '0));
endmodule

// File: rtl/cfgport_ldev.sv
module cfgport_ldev
  import cfgport_pkg::*;
#(
  parameter logic [DW-1:0] LDN_ID = 8'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [DW-1:0]     idx,
  input  logic [DW-1:0]     ldsel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_byte_o,
  output logic              en_o,
  output logic [BASE_W-1:0] base_o
);
  logic          act_q, mem_q;
  logic [DW-1:0] hi_q, lo_q;
  logic          sel;

  assign sel = (ldsel == LDN_ID) && (idx >= IDX_BANKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      mem_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (data_wr && sel) begin
      case (idx)
        IDX_ACT:     act_q <= wdata[0];
        IDX_MAP:     mem_q <= wdata[0];
        IDX_BASE_HI: hi_q  <= wdata;
        IDX_BASE_LO: lo_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      base_o <= '0;
    end else begin
      en_o   <= act_q && !mem_q && ({hi_q, lo_q} != '0);
      base_o <= {hi_q, lo_q};
    end
  end

  always_comb begin
    rd_byte_o = '0;
    if (sel) begin
      case (idx)
        IDX_ACT:     rd_byte_o = {{(DW-1){1'b0}}, act_q};
        IDX_MAP:     rd_byte_o = {{(DW-1){1'b0}}, mem_q};
        IDX_BASE_HI: rd_byte_o = hi_q;
        IDX_BASE_LO: rd_byte_o = lo_q;
        default:     rd_byte_o = '0;
      endcase
    end
  end

  a_r7_en_needs_base: assert property (@(posedge clk) disable iff (rst)
    en_o |-> (base_o != '0));
  a_r6_base_follows: assert property (@(posedge clk) disable iff (rst)
    base_o == $past({hi_q, lo_q}));
  a_r8_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !sel) |=> $stable({act_q, mem_q, hi_q, lo_q}));
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int                   NDEV     = 2,
  parameter logic [NDEV*DW-1:0]   LDN_LIST = {8'h14, 8'h09},
  parameter logic [DW-1:0]        DEV_ID   = 8'hF2,
  parameter logic [DW-1:0]        PIN_RST  = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic                     bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic [NDEV-1:0]          dev_en,
  output logic [NDEV*BASE_W-1:0]   dev_base,
  output logic                     sess_end
);
  logic [DW-1:0] idx, ldsel, glob_rd;
  logic [DW-1:0] dev_rd [NDEV];
  logic [DW-1:0] bank_rd;
  logic          idx_wr, data_wr;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr &&  bus_addr;

  cfgport_glob #(.DEV_ID(DEV_ID), .PIN_RST(PIN_RST)) u_glob (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(bus_wdata),
    .idx_o(idx), .ldsel_o(ldsel), .rd_byte_o(glob_rd), .end_o(sess_end)
  );

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    cfgport_ldev #(.LDN_ID(LDN_LIST[g*DW +: DW])) u_ldev (
      .clk(clk), .rst(rst), .data_wr(data_wr), .idx(idx), .ldsel(ldsel),
      .wdata(bus_wdata), .rd_byte_o(dev_rd[g]), .en_o(dev_en[g]),
      .base_o(dev_base[g*BASE_W +: BASE_W])
    );
  end

  always_comb begin
    bank_rd = '0;
    for (int i = 0; i < NDEV; i++) bank_rd = bank_rd | dev_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_addr ? (glob_rd | bank_rd) : idx;
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
  a_r3_devid: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr && idx == IDX_DEVID) |=> (bus_rdata == DEV_ID));
endmodule

// File: tb/cfgport_top_tb.sv
`timescale 1ns/1ps
module cfgport_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  dev_en;
  logic [31:0] dev_base;
  logic        sess_end;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  cfgport_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_en(dev_en),
    .dev_base(dev_base), .sess_end(sess_end)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item for each read sampled by the design
  always @(posedge clk) rd_seen <= bus_rd && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual=%h expected=<none>", bus_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, {24'b0, bus_rdata}, {24'b0, it.exp});
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    it.exp = exp; it.tag = tag; sb.push_back(it);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(1'b0, i); wr(1'b1, d);
  endtask

  task automatic cfg_rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
    wr(1'b0, i); rd(1'b1, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dev_en", {30'b0, dev_en}, 32'h0);
    chk("R1 dev_base", dev_base, 32'h0);
    chk("R1 sess_end", {31'b0, sess_end}, 32'h0);
    chk("R1 rdata", {24'b0, bus_rdata}, 32'h0);
    rd(1'b0, 8'h00, "R1 index");
    cfg_rd(8'h22, 8'h00, "R1 pin reset");

    // R2 index readback
    wr(1'b0, 8'h5A);
    rd(1'b0, 8'h5A, "R2 index readback");

    // R3 device ID, write ignored
    cfg_rd(8'h20, 8'hF2, "R3 id");
    cfg_wr(8'h20, 8'h00);
    cfg_rd(8'h20, 8'hF2, "R3 id after write");

    // R4 select device 0x09
    cfg_wr(8'h07, 8'h09);
    cfg_rd(8'h07, 8'h09, "R4 ldsel readback");

    // R5 activation
    cfg_wr(8'h30, 8'hFF);
    cfg_rd(8'h30, 8'h01, "R5 act bit");
    @(negedge clk);
    chk("R7 no base no enable", {30'b0, dev_en}, 32'h0);

    // R6 base
    cfg_wr(8'h60, 8'h02);
    cfg_wr(8'h61, 8'h90);
    @(negedge clk);
    chk("R6 base dev0", {16'b0, dev_base[15:0]}, 32'h0290);
    chk("R7 enable dev0", {30'b0, dev_en}, 32'h1);
    chk("R4 dev1 untouched", {16'b0, dev_base[31:16]}, 32'h0);
    cfg_rd(8'h61, 8'h90, "R6 low readback");

    // R7 memory mapping gates enable
    cfg_wr(8'h50, 8'h01);
    @(negedge clk);
    chk("R7 mem mapped", {30'b0, dev_en}, 32'h0);
    cfg_wr(8'h50, 8'h00);
    @(negedge clk);
    chk("R7 io mapped", {30'b0, dev_en}, 32'h1);

    // R4 second device
    cfg_wr(8'h07, 8'h14);
    cfg_rd(8'h30, 8'h00, "R4 dev1 inactive");
    cfg_wr(8'h60, 8'h0A);
    cfg_wr(8'h61, 8'h00);
    cfg_wr(8'h30, 8'h01);
    @(negedge clk);
    chk("R4 base dev1", {16'b0, dev_base[31:16]}, 32'h0A00);
    chk("R4 base dev0 kept", {16'b0, dev_base[15:0]}, 32'h0290);
    chk("R7 both enabled", {30'b0, dev_en}, 32'h3);

    // R8 unknown device number
    cfg_wr(8'h07, 8'h05);
    cfg_rd(8'h60, 8'h00, "R8 read empty");
    cfg_wr(8'h30, 8'h00);
    cfg_wr(8'h60, 8'h00);
    @(negedge clk);
    chk("R8 enables kept", {30'b0, dev_en}, 32'h3);
    chk("R8 bases kept", dev_base, 32'h0A00_0290);

    // R9 pin bytes
    cfg_wr(8'h22, 8'hA5);
    cfg_wr(8'h2D, 8'h3C);
    cfg_wr(8'h25, 8'h11);
    cfg_rd(8'h22, 8'hA5, "R9 pin 0x22");
    cfg_rd(8'h2D, 8'h3C, "R9 pin 0x2D");
    cfg_rd(8'h25, 8'h11, "R9 pin 0x25");
    cfg_rd(8'h2B, 8'h00, "R9 pin 0x2B");

    // R10 unimplemented
    cfg_wr(8'h26, 8'h77);
    cfg_rd(8'h26, 8'h00, "R10 idx 0x26");
    cfg_wr(8'h07, 8'h09);
    cfg_wr(8'h40, 8'h77);
    cfg_rd(8'h40, 8'h00, "R10 banked 0x40");
    cfg_rd(8'h60, 8'h02, "R10 neighbour kept");

    // R11 session end
    cfg_wr(8'h02, 8'h01);
    chk("R11 wrong code", {31'b0, sess_end}, 32'h0);
    rd(1'b0, 8'h02, "R11 index kept");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h02);
    chk("R11 pulse", {31'b0, sess_end}, 32'h1);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, sess_end}, 32'h0);
    rd(1'b0, 8'h00, "R11 index home");

    // R12 read data holds
    cfg_rd(8'h20, 8'hF2, "R12 load");
    wr(1'b0, 8'h40);
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R12 held", {24'b0, bus_rdata}, 32'hF2);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset en", {30'b0, dev_en}, 32'h0);
    chk("R1 re-reset base", dev_base, 32'h0);
    cfg_rd(8'h22, 8'h00, "R1 pin after reset");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12: actual=%0d pending expected=0", sb.size());
    end
    finish_run();
  end
endmodule